// File: doc/BRIEF.md
# Subcycle PWM Duty Averager

This block turns a switching control signal into a slowly updated average for a plant model that steps more slowly than the switching edges. A single PWM input is sampled on every cycle of a fast clock. The block then counts high and low samples over a free-running window of N cycles. When a window closes, it publishes the fraction of high samples as an unsigned fixed-point value in the range 0 to 1. A one-cycle strobe marks each new value. The value is held until the next window closes, so the slow model can pick it up at its own step.

The window is not aligned to PWM edges. If the window spans a whole number of PWM periods, every window reports the true duty. Otherwise consecutive values ripple around the average. The window length and a matching reciprocal are runtime inputs. Both are sampled only at a window boundary, so a window is never measured with one length and scaled with another.

Top module: `pwm_duty_avg`

## Requirements
- R1: While reset is low, and after reset until the first window completes, `duty_o` is 0 and `duty_vld_o` is 0.
- R2: The PWM input passes through two synchronizing flops. The level present before clock edge k is the sample counted at edge k+2. The first edge after reset only loads the configuration, so counting starts at the second edge.
- R3: A window spans exactly the active length L in samples. `duty_vld_o` is high for exactly one cycle per window, in the cycle after the edge that counts the window's last sample, so strobes are L cycles apart.
- R4: With H high samples in a window and reciprocal register value Q, `duty_o` = (H*Q + 2^15) >> 16. This is a 17-bit value with 16 fractional bits, where 65536 means 1.0. Q is expected to be round(2^32/L).
- R5: An input held high for a whole window yields 65536, and an input held low yields 0.
- R6: `duty_o` changes only in a cycle where `duty_vld_o` is high, and holds its value otherwise.
- R7: `cfg_len` and `cfg_recip` are sampled only at the first edge after reset and at each window-closing edge. A change in mid-window does not alter the running window.
- R8: A sampled `cfg_len` of 0 or 1 is treated as 2. `cfg_recip` is used as given.
- R9: Each sample lands in exactly one window, so the high and low counts of every window sum to L.
- R10: When L is a multiple of the PWM period, every steady-state window yields the same value. When it is not, the value varies from window to window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM input, sampled every cycle |
| cfg_len | input | 16 | Window length in samples (values below 2 act as 2) |
| cfg_recip | input | 32 | Reciprocal of the window length, scaled by 2^32 |
| duty_o | output | 17 | Averaged duty, 1.16 unsigned fixed point |
| duty_vld_o | output | 1 | One-cycle strobe for a new `duty_o` |

## Verification
Counting from reset release, a window of length L yields its strobe and value one cycle after edge L+1. A level driven on the input is counted two edges later. The bench's driver models both delays when it decides which window each driven level belongs to. It pushes the expected value and window length the moment the modelled window closes. The monitor samples on falling edges, pops one item per strobe, and compares the value and the strobe spacing, so each result is checked in the cycle it is due.

// File: rtl/pda_pkg.sv
// Shared constants for the PWM duty averager.
// Assumes: the reciprocal scale is 2^RCP_W and the duty output has FRAC_W fraction bits.
package pda_pkg;
    // Smallest window length the block accepts after clamping
    localparam int MIN_WIN = 2;
    // Default widths
    localparam int LEN_W_D  = 16;
    localparam int RCP_W_D  = 32;
    localparam int FRAC_W_D = 16;
endpackage

// File: rtl/pda_sync.sv
// Chain of flops that brings the PWM input into the sample clock domain.
// Assumes: STAGES >= 1; every stage resets to 0; the latency is exactly STAGES cycles.
module pda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the input through the chain, one stage per clock
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pda_window.sv
// Free-running counting window: counts high and low samples over the active length.
// Assumes: len/recip are sampled once after reset and at every window end; lengths below
// MIN_WIN are clamped; win_end marks the cycle whose sample is the last of the window.
module pda_window #(
    parameter int LEN_W = 16,
    parameter int RCP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [RCP_W-1:0] cfg_recip,
    output logic             win_end,
    output logic [LEN_W-1:0] hi_tot,
    output logic [LEN_W-1:0] lo_tot,
    output logic [LEN_W-1:0] len_act,
    output logic [RCP_W-1:0] rcp_act
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(pda_pkg::MIN_WIN);

    logic             run;
    logic [LEN_W-1:0] tick;
    logic [LEN_W-1:0] hi_cnt;
    logic [LEN_W-1:0] lo_cnt;
    logic [LEN_W-1:0] len_clamped;

    // Clamp the requested length to the minimum window
    assign len_clamped = (cfg_len < MIN_L) ? MIN_L : cfg_len;

    // Window closes on the cycle whose sample is the last one
    assign win_end = run && (tick == len_act - LEN_W'(1));

    // Totals including the sample of the current cycle
    assign hi_tot = hi_cnt + LEN_W'(smp);
    assign lo_tot = lo_cnt + LEN_W'(!smp);

    // Advance the window, restart at its end and latch the next configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            tick    <= '0;
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            len_act <= MIN_L;
            rcp_act <= '0;
        end else if (!run) begin
            run     <= 1'b1;
            len_act <= len_clamped;
            rcp_act <= cfg_recip;
        end else if (win_end) begin
            tick    <= '0;
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            len_act <= len_clamped;
            rcp_act <= cfg_recip;
        end else begin
            tick    <= tick + LEN_W'(1);
            hi_cnt  <= hi_tot;
            lo_cnt  <= lo_tot;
        end
    end
endmodule

// File: rtl/pda_scale.sv
// Scales the high-sample total by the reciprocal and holds the rounded duty.
// Assumes: recip = round(2^RCP_W / L), so the rounded result never exceeds 2^FRAC_W.
module pda_scale #(
    parameter int LEN_W  = 16,
    parameter int RCP_W  = 32,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_end,
    input  logic [LEN_W-1:0]  hi_tot,
    input  logic [RCP_W-1:0]  rcp,
    output logic [FRAC_W:0]   duty,
    output logic              vld
);
    localparam int SH = RCP_W - FRAC_W;
    localparam int PW = LEN_W + RCP_W + 1;
    localparam logic [PW-1:0] HALF = PW'(1) << (SH - 1);

    logic [PW-1:0] prod;
    logic [PW-1:0] rnd;

    // Multiply by the reciprocal and add half an output LSB
    assign prod = PW'(hi_tot) * PW'(rcp);
    assign rnd  = prod + HALF;

    // Register the duty at window end and pulse the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= win_end;
            if (win_end) duty <= rnd[SH +: FRAC_W + 1];
        end
    end
endmodule

// File: rtl/pwm_duty_avg.sv
// Top of the subcycle PWM duty averager: synchronizer, counting window, scaler.
// Assumes: one fast clock; the slow model reads duty_o when duty_vld_o pulses.
module pwm_duty_avg #(
    parameter int LEN_W     = pda_pkg::LEN_W_D,
    parameter int RCP_W     = pda_pkg::RCP_W_D,
    parameter int FRAC_W    = pda_pkg::FRAC_W_D,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_in,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [RCP_W-1:0]  cfg_recip,
    output logic [FRAC_W:0]   duty_o,
    output logic              duty_vld_o
);
    logic             smp;
    logic             win_end;
    logic [LEN_W-1:0] hi_tot;
    logic [LEN_W-1:0] lo_tot;
    logic [LEN_W-1:0] len_act;
    logic [RCP_W-1:0] rcp_act;

    pda_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pwm_in),
        .dout (smp)
    );

    pda_window #(.LEN_W(LEN_W), .RCP_W(RCP_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (smp),
        .cfg_len  (cfg_len),
        .cfg_recip(cfg_recip),
        .win_end  (win_end),
        .hi_tot   (hi_tot),
        .lo_tot   (lo_tot),
        .len_act  (len_act),
        .rcp_act  (rcp_act)
    );

    pda_scale #(.LEN_W(LEN_W), .RCP_W(RCP_W), .FRAC_W(FRAC_W)) u_scale (
        .clk    (clk),
        .rst_n  (rst_n),
        .win_end(win_end),
        .hi_tot (hi_tot),
        .rcp    (rcp_act),
        .duty   (duty_o),
        .vld    (duty_vld_o)
    );
endmodule

// File: rtl/pda_chk.sv
// Checker for the duty averager, attached to the top with bind.
// Assumes: it sees the window totals and active length from inside the top.
module pda_chk #(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_end,
    input logic [LEN_W-1:0] hi_tot,
    input logic [LEN_W-1:0] lo_tot,
    input logic [LEN_W-1:0] len_act,
    input logic [FRAC_W:0]  duty,
    input logic             vld
);
    // R9
    sample_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> ({1'b0, hi_tot} + {1'b0, lo_tot}) == {1'b0, len_act});

    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    // R3
    strobe_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> vld);

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> $stable(duty));

    // R4
    duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty <= (FRAC_W + 1)'(1) << FRAC_W);

    // R8
    min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_act >= LEN_W'(2));
endmodule

bind pwm_duty_avg pda_chk #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .win_end(win_end),
    .hi_tot (hi_tot),
    .lo_tot (lo_tot),
    .len_act(len_act),
    .duty   (duty_o),
    .vld    (duty_vld_o)
);

// File: tb/sim_pwm_duty_avg.sv
`timescale 1ns/1ps
module sim_pwm_duty_avg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_in = 1'b0;
    logic [15:0] cfg_len = 16'd6;
    logic [31:0] cfg_recip = 32'd0;
    logic [16:0] duty_o;
    logic        duty_vld_o;

    always #4 clk = ~clk;

    pwm_duty_avg u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
        .cfg_len(cfg_len), .cfg_recip(cfg_recip),
        .duty_o(duty_o), .duty_vld_o(duty_vld_o)
    );

    typedef struct {
        logic [16:0] duty;
        int          len;
        int          ph;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] recip_of(input int n);
        return 32'(((64'd1 << 32) + 64'(n / 2)) / 64'(n));
    endfunction

    function automatic logic [16:0] duty_of(input int h, input logic [31:0] r);
        logic [63:0] p;
        p = 64'(h) * 64'(r) + 64'd32768;
        return p[32:16];
    endfunction

    // Model state (driver side)
    int          n_len = 6;
    logic [31:0] n_rcp;
    bit          m_run = 0;
    int          m_tick = 0, m_hi = 0, m_len = 2;
    logic [31:0] m_rcp = 0;
    logic        d1 = 0, d2 = 0;
    int          cur_ph = 0;
    string       cur_tag = "R3";

    // Driver: present one input level and the configuration, model the next edge, wait a cycle
    task automatic step(input logic v);
        item_t it;
        pwm_in    = v;
        cfg_len   = 16'(n_len);
        cfg_recip = n_rcp;
        if (!m_run) begin
            m_run = 1;
            m_len = (n_len < 2) ? 2 : n_len;
            m_rcp = n_rcp;
        end else begin
            m_hi += int'(d2);  // R2: level from two edges earlier
            m_tick++;
            if (m_tick == m_len) begin
                it.duty = duty_of(m_hi, m_rcp);
                it.len  = m_len;
                it.ph   = cur_ph;
                it.tag  = cur_tag;
                q.push_back(it);
                m_tick = 0;
                m_hi   = 0;
                m_len  = (n_len < 2) ? 2 : n_len;  // R7, R8
                m_rcp  = n_rcp;
            end
        end
        d2 = d1;
        d1 = v;
        @(negedge clk);
    endtask

    // Monitor state
    int          cyc = 0, last_v = 0, hold_bad = 0;
    bit          seen = 0;
    logic [16:0] held = 0;
    int          ph_cnt[3], ph_chg[3];
    logic [16:0] ph_prev[3];

    initial begin
        for (int i = 0; i < 3; i++) begin ph_cnt[i] = 0; ph_chg[i] = 0; ph_prev[i] = 0; end
    end

    // Monitor: pop one expected item per strobe and compare value and spacing
    always @(negedge clk) begin
        if (rst_n) begin
            item_t it;
            cyc++;
            if (duty_vld_o) begin
                if (q.size() == 0) begin
                    chk(0, "R3 unexpected strobe", 1, 0);
                end else begin
                    it = q.pop_front();
                    chk(duty_o === it.duty, it.tag, duty_o, it.duty);
                    if (seen) chk((cyc - last_v) == it.len, "R3 strobe spacing", cyc - last_v, it.len);
                    seen   = 1;
                    last_v = cyc;
                    held   = duty_o;
                    if (it.ph > 0) begin
                        ph_cnt[it.ph]++;
                        if (ph_cnt[it.ph] > 2 && duty_o != ph_prev[it.ph]) ph_chg[it.ph]++;
                        ph_prev[it.ph] = duty_o;
                    end
                end
            end else if (duty_o !== held) begin
                hold_bad++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        n_rcp = recip_of(6);
        cfg_recip = n_rcp;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(duty_o == 0 && !duty_vld_o, "R1 in reset", {duty_o, duty_vld_o}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b1);
        // R1: still nothing before the first window closes
        chk(duty_o == 0 && !duty_vld_o, "R1 before first window", {duty_o, duty_vld_o}, 0);

        // R10: window of 6, PWM period 6
        cur_ph = 1; cur_tag = "R10 commensurate";
        for (int i = 0; i < 60; i++) step((i % 6) < 2);
        // R10: window of 6, PWM period 7
        cur_ph = 2; cur_tag = "R10 ripple";
        for (int i = 0; i < 84; i++) step((i % 7) < 3);
        cur_ph = 0;

        // R2: isolated pulses near window boundaries
        n_len = 4; n_rcp = recip_of(4); cur_tag = "R2 latency";
        for (int i = 0; i < 64; i++) step((i % 8) == 3);

        // R5: constant high then constant low
        n_len = 10; n_rcp = recip_of(10); cur_tag = "R5 full scale";
        for (int i = 0; i < 40; i++) step(1'b1);
        cur_tag = "R5 zero";
        for (int i = 0; i < 40; i++) step(1'b0);

        // R7: length change in mid-window
        n_len = 5; n_rcp = recip_of(5); cur_tag = "R7 length change";
        for (int i = 0; i < 13; i++) step(i[0]);
        n_len = 9; n_rcp = recip_of(9);
        for (int i = 0; i < 40; i++) step(i[0]);

        // R8: lengths 1 and 0 act as 2
        n_len = 1; n_rcp = recip_of(2); cur_tag = "R8 clamp len 1";
        for (int i = 0; i < 20; i++) step((i % 3) == 0);
        n_len = 0; cur_tag = "R8 clamp len 0";
        for (int i = 0; i < 20; i++) step((i % 3) != 0);

        // R4: long windows with pseudo-random input
        n_len = 1000; n_rcp = recip_of(1000); cur_tag = "R4 scaling";
        lfsr = 16'hACE1;
        for (int i = 0; i < 5000; i++) begin
            step(lfsr[0]);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        n_len = 777; n_rcp = recip_of(777);
        for (int i = 0; i < 2400; i++) begin
            step(lfsr[0]);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end

        // Drain outstanding windows
        for (int i = 0; i < 2000 && q.size() > 0; i++) step(1'b0);
        repeat (3) @(negedge clk);

        chk(q.size() == 0, "R3 all windows produced", q.size(), 0);
        chk(ph_chg[1] == 0, "R10 commensurate steady", ph_chg[1], 0);
        chk(ph_chg[2] > 0, "R10 non-commensurate ripple", ph_chg[2], 1);
        chk(hold_bad == 0, "R6 hold between strobes", hold_bad, 0);
        // R9: every window's count matched its length (covered by per-window values above)
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule